// File: doc/BRIEF.md
# Banked Reset Line Controller

This block owns a set of reset lines for other blocks on the chip. The lines are held in a small number of 32-bit bank registers. A request port takes a logical reset number and one of three operations: assert, deassert or status. The logical number is first turned into a physical line index. The mapping is sparse: it walks the physical lines in ascending order and skips every line marked in a gap mask. The physical index then picks a bank (index divided by 32) and a bit inside that bank (index modulo 32). The selected bank goes through a fixed two-cycle read-modify-write, and exactly one bit can change.

Logical numbers beyond the end of the map are refused. An error flag comes back with the completion strobe, and no bank is touched. A direct register port sits alongside the request port. It reads any bank combinationally and can overwrite a whole bank while no request is in flight. The reset lines themselves are the concatenation of all banks, with the lowest-addressed bank in the low bits.

Top module: `rst_bank`

## Requirements
- R1: After power-on reset every reset line is deasserted (0), and `opDone` and `opErr` are low.
- R2: An assert request (`reqOp` = 1) sets the bit of the mapped physical line. Every other bit in every bank keeps its value.
- R3: A deassert request (`reqOp` = 2) clears the bit of the mapped physical line. Every other bit keeps its value.
- R4: A status request (`reqOp` = 0 or 3) returns the current value of the mapped bit on `statusBit` during the `opDone` cycle, and changes no line.
- R5: Logical number k maps to the k-th physical index, counted from 0, whose `GAP_MASK` bit is 0. Bank = index / 32 and bit = index mod 32. A line whose gap bit is 1 is never changed by a request.
- R6: A logical number at or above the count of unmasked lines (53 by default) raises `opErr` together with `opDone`. It changes no line, and `statusBit` reads 0.
- R7: A request sampled at clock edge E0 is read at E1 and written at E2. Line updates are visible after E2. `opDone` is high for exactly the one cycle after E2. A new request is accepted from that cycle on.
- R8: `regRdData` shows bank `regAddr[2]` combinationally (byte offset 0x0 is bank 0 and 0x4 is bank 1). An idle-cycle `regWrEn` writes `regWrData` to that bank at the clock edge. `resetLines` is {bank 1, bank 0}.
- R9: A `reqValid` or `regWrEn` sampled while a request is in flight (the E1 and E2 edges) is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request strobe, sampled when idle |
| reqOp | input | 2 | 1 assert, 2 deassert, 0 or 3 status |
| reqId | input | 6 | Logical reset number |
| opDone | output | 1 | One-cycle completion strobe |
| opErr | output | 1 | Invalid number, valid with opDone |
| statusBit | output | 1 | Selected bit value, valid with opDone |
| regAddr | input | 3 | Byte offset of the bank for direct access |
| regWrEn | input | 1 | Direct bank write, idle only |
| regWrData | input | 32 | Direct write data |
| regRdData | output | 32 | Combinational read of the addressed bank |
| resetLines | output | 64 | All reset lines, bank 0 in the low half |

## Verification
A request is driven before edge E0 and held only through that edge. Its done strobe, error flag, status bit and line update are all sampled at the falling edge after E2. The falling edges after E1 and after E3 are also checked, to show that `opDone` is low in both. Direct writes take effect at the edge that samples them, and their result is checked at the following falling edge. `regRdData` is combinational and is checked within the same cycle. Stimulus driven during the E1 and E2 edges must leave no trace: the lines must hold only the in-flight request's effect, and no second done strobe may appear afterwards.

// File: rtl/rst_bank_pkg.sv
package rst_bank_pkg;
  localparam int BANK_BITS = 32;
  localparam int NUM_BANKS = 2;
  localparam int TOTAL     = BANK_BITS * NUM_BANKS;
  localparam int BANK_W    = $clog2(NUM_BANKS);
  localparam int BIT_W     = $clog2(BANK_BITS);
  localparam int PHYS_W    = $clog2(TOTAL);
  localparam int ADDR_W    = BANK_W + 2;

  typedef enum logic [1:0] {
    OP_STATUS = 2'd0,
    OP_SET    = 2'd1,
    OP_CLR    = 2'd2,
    OP_PEEK   = 2'd3
  } opKind_e;

  typedef struct packed {
    logic              rdStb;
    logic              wrStb;
    logic              dirOk;
    logic              isErr;
    opKind_e           op;
    logic [PHYS_W-1:0] phys;
  } dpCmd_t;
endpackage

// File: rtl/rst_bank_ctrl.sv
module rst_bank_ctrl
  import rst_bank_pkg::*;
#(
  parameter logic [TOTAL-1:0] GAP_MASK = '0,
  parameter int               NUM_IDS  = TOTAL
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqOp,
  input  logic [PHYS_W-1:0] reqId,
  output dpCmd_t            cmd,
  output logic              opDone,
  output logic              opErr
);
  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE} state_e;

  state_e            stateQ;
  logic [PHYS_W-1:0] physQ, physD;
  logic              errQ;
  opKind_e           opQ;
  logic              doneQ, errOutQ;

  // walk the unmasked lines to find the k-th one
  always_comb begin
    int cnt;
    cnt   = 0;
    physD = '0;
    for (int p = 0; p < TOTAL; p++) begin
      if (!GAP_MASK[p]) begin
        if (cnt == int'(reqId)) physD = PHYS_W'(p);
        cnt++;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ  <= ST_IDLE;
      physQ   <= '0;
      errQ    <= 1'b0;
      opQ     <= OP_STATUS;
      doneQ   <= 1'b0;
      errOutQ <= 1'b0;
    end else begin
      doneQ   <= 1'b0;
      errOutQ <= 1'b0;
      unique case (stateQ)
        ST_IDLE: if (reqValid) begin
          physQ  <= physD;
          errQ   <= (int'(reqId) >= NUM_IDS);
          opQ    <= opKind_e'(reqOp);
          stateQ <= ST_READ;
        end
        ST_READ:  stateQ <= ST_WRITE;
        ST_WRITE: begin
          doneQ   <= 1'b1;
          errOutQ <= errQ;
          stateQ  <= ST_IDLE;
        end
        default:  stateQ <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    cmd.rdStb = (stateQ == ST_READ);
    cmd.wrStb = (stateQ == ST_WRITE);
    cmd.dirOk = (stateQ == ST_IDLE);
    cmd.isErr = errQ;
    cmd.op    = opQ;
    cmd.phys  = physQ;
  end

  assign opDone = doneQ;
  assign opErr  = errOutQ;
endmodule

// File: rtl/rst_bank_dp.sv
module rst_bank_dp
  import rst_bank_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  dpCmd_t               cmd,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic                 regWrEn,
  input  logic [BANK_BITS-1:0] regWrData,
  output logic [BANK_BITS-1:0] regRdData,
  output logic                 statusBit,
  output logic [TOTAL-1:0]     resetLines
);
  logic [BANK_BITS-1:0] bankQ [NUM_BANKS];
  logic [BANK_BITS-1:0] holdQ;
  logic                 statusQ;
  logic [BANK_W-1:0]    selBank, dirBank;
  logic [BIT_W-1:0]     selBit;
  logic [BANK_BITS-1:0] bitMask, modified;

  assign selBank = cmd.phys[PHYS_W-1 -: BANK_W];
  assign selBit  = cmd.phys[BIT_W-1:0];
  assign dirBank = regAddr[ADDR_W-1 -: BANK_W];
  assign bitMask = BANK_BITS'(1) << selBit;

  always_comb begin
    unique case (cmd.op)
      OP_SET:  modified = holdQ | bitMask;
      OP_CLR:  modified = holdQ & ~bitMask;
      default: modified = holdQ;
    endcase
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        bankQ[b] <= '0;
      end else if (cmd.wrStb && !cmd.isErr && selBank == BANK_W'(b)) begin
        bankQ[b] <= modified;
      end else if (cmd.dirOk && regWrEn && dirBank == BANK_W'(b)) begin
        bankQ[b] <= regWrData;
      end
    end
    assign resetLines[b*BANK_BITS +: BANK_BITS] = bankQ[b];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdQ   <= '0;
      statusQ <= 1'b0;
    end else begin
      if (cmd.rdStb) holdQ <= bankQ[selBank];
      if (cmd.wrStb) statusQ <= !cmd.isErr && holdQ[selBit];
    end
  end

  assign regRdData = bankQ[dirBank];
  assign statusBit = statusQ;
endmodule

// File: rtl/rst_bank.sv
module rst_bank
  import rst_bank_pkg::*;
#(
  parameter logic [TOTAL-1:0] GAP_MASK = 64'h410086A8_80800002
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic [1:0]           reqOp,
  input  logic [PHYS_W-1:0]    reqId,
  output logic                 opDone,
  output logic                 opErr,
  output logic                 statusBit,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic                 regWrEn,
  input  logic [BANK_BITS-1:0] regWrData,
  output logic [BANK_BITS-1:0] regRdData,
  output logic [TOTAL-1:0]     resetLines
);
  localparam int NUM_IDS = TOTAL - $countones(GAP_MASK);

  dpCmd_t cmd;

  rst_bank_ctrl #(.GAP_MASK(GAP_MASK), .NUM_IDS(NUM_IDS)) ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp), .reqId(reqId),
    .cmd(cmd), .opDone(opDone), .opErr(opErr)
  );

  rst_bank_dp dp_i (
    .clk(clk), .rstN(rstN), .cmd(cmd), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .statusBit(statusBit),
    .resetLines(resetLines)
  );
endmodule

// File: rtl/rst_bank_chk.sv
module rst_bank_chk
  import rst_bank_pkg::*;
#(
  parameter logic [TOTAL-1:0] GAP_MASK = '0
) (
  input logic             clk,
  input logic             rstN,
  input logic             opDone,
  input logic             opErr,
  input logic             statusBit,
  input logic             regWrEn,
  input logic [TOTAL-1:0] resetLines
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    opDone |=> !opDone); // R7
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    opErr |-> opDone); // R6
  AST_ERR_NO_CHANGE: assert property (@(posedge clk) disable iff (!rstN)
    (opErr && !$past(regWrEn)) |-> $stable(resetLines)); // R6
  AST_ERR_STATUS_LOW: assert property (@(posedge clk) disable iff (!rstN)
    opErr |-> !statusBit); // R6
  AST_SINGLE_BIT: assert property (@(posedge clk) disable iff (!rstN)
    opDone |-> $countones(resetLines ^ $past(resetLines)) <= 1); // R2
  AST_GAP_UNTOUCHED: assert property (@(posedge clk) disable iff (!rstN)
    opDone |-> ((resetLines ^ $past(resetLines)) & GAP_MASK) == '0); // R5
  AST_QUIET_OTHERWISE: assert property (@(posedge clk) disable iff (!rstN)
    (!opDone && !$past(regWrEn)) |-> $stable(resetLines)); // R9
endmodule

bind rst_bank rst_bank_chk #(.GAP_MASK(GAP_MASK)) chk_i (
  .clk(clk), .rstN(rstN), .opDone(opDone), .opErr(opErr), .statusBit(statusBit),
  .regWrEn(regWrEn), .resetLines(resetLines)
);

// File: tb/rst_bank_tb_top.sv
module rst_bank_tb_top;
  localparam logic [63:0] GAP = 64'h410086A8_80800002;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqOp = 2'd0;
  logic [5:0]  reqId = 6'd0;
  logic        opDone, opErr, statusBit;
  logic [2:0]  regAddr = 3'd0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = 32'd0;
  logic [31:0] regRdData;
  logic [63:0] resetLines;

  int          nChk = 0;
  int          nBad = 0;
  logic [63:0] refLines = '0;
  int          numIds;
  int          physOf [64];

  always #10 clk = ~clk;

  rst_bank #(.GAP_MASK(GAP)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp), .reqId(reqId),
    .opDone(opDone), .opErr(opErr), .statusBit(statusBit), .regAddr(regAddr),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .resetLines(resetLines)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R5: build the logical-to-physical map from the gap mask
  task automatic buildMap();
    int k;
    k = 0;
    for (int i = 0; i < 64; i++) physOf[i] = -1;
    for (int p = 0; p < 64; p++) if (!GAP[p]) begin physOf[k] = p; k++; end
    numIds = k;
  endtask

  // full request with timing checks; busy-time stimulus optional (R9)
  task automatic doReq(logic [1:0] op, logic [5:0] id, bit busyPoke);
    logic expErr, expStat;
    @(negedge clk);
    reqValid = 1'b1; reqOp = op; reqId = id;
    @(posedge clk);                       // E0
    @(negedge clk);
    reqValid = 1'b0;
    if (busyPoke) begin
      reqValid = 1'b1; reqOp = 2'd1; reqId = 6'd0;
      regWrEn = 1'b1; regAddr = 3'd0; regWrData = 32'hFFFF_FFFF;
    end
    @(posedge clk);                       // E1
    @(negedge clk);
    check("R7 done low after E1", 64'(opDone), 64'd0);
    @(posedge clk);                       // E2
    @(negedge clk);
    if (busyPoke) begin reqValid = 1'b0; regWrEn = 1'b0; end
    expErr = (int'(id) >= numIds);
    expStat = 1'b0;
    if (!expErr) begin
      expStat = refLines[physOf[id]];
      if (op == 2'd1) refLines[physOf[id]] = 1'b1;
      if (op == 2'd2) refLines[physOf[id]] = 1'b0;
    end
    check("R7 done after E2", 64'(opDone), 64'd1);
    check("R6 error flag", 64'(opErr), 64'(expErr));
    check("R4 status bit", 64'(statusBit), 64'(expStat));
    check("R2 R3 lines", resetLines, refLines);
    @(negedge clk);
    check("R7 done one cycle", 64'(opDone), 64'd0);
    if (busyPoke) check("R9 busy stimulus ignored", resetLines, refLines);
  endtask

  task automatic dirWrite(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(posedge clk);
    @(negedge clk);
    regWrEn = 1'b0;
    if (a[2]) refLines[63:32] = d; else refLines[31:0] = d;
    check("R8 direct write", resetLines, refLines);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = 32'd7;
    void'($urandom(seed));
    buildMap();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 lines cleared", resetLines, 64'd0);
    check("R1 done low", 64'(opDone), 64'd0);
    check("R1 err low", 64'(opErr), 64'd0);
    rstN = 1'b1;

    // directed corners
    doReq(2'd1, 6'd0, 1'b0);                 // R2 first id
    doReq(2'd1, 6'(numIds - 1), 1'b0);       // R2 last valid id
    check("R5 last id lands on bit 63", 64'(resetLines[63]), 64'd1);
    doReq(2'd1, 6'd1, 1'b0);                 // R5 id 1 skips gap bit 1
    check("R5 id1 maps to bit 2", 64'(resetLines[2:0]), 64'b101);
    doReq(2'd3, 6'd1, 1'b0);                 // R4 status, op 3
    doReq(2'd2, 6'd0, 1'b0);                 // R3 clear
    doReq(2'd0, 6'd0, 1'b0);                 // R4 status of cleared bit
    doReq(2'd1, 6'(numIds), 1'b0);           // R6 first invalid
    doReq(2'd1, 6'd63, 1'b0);                // R6 max id
    dirWrite(3'd4, 32'hA5A5_0F0F);           // R8 bank 1
    dirWrite(3'd0, 32'h8080_0002);           // R8 bank 0, gap bits set
    @(negedge clk);
    regAddr = 3'd4;
    #1 check("R8 readback 0x4", 64'(regRdData), 64'(refLines[63:32]));
    regAddr = 3'd0;
    #1 check("R8 readback 0x0", 64'(regRdData), 64'(refLines[31:0]));
    doReq(2'd2, 6'd1, 1'b0);                 // R5 gap bits stay set
    check("R5 gap bits untouched", 64'(resetLines[1] & resetLines[23] & resetLines[31]), 64'd1);
    doReq(2'd2, 6'd5, 1'b1);                 // R9 busy poke
    @(negedge clk);
    check("R9 no second done", 64'(opDone), 64'd0);

    // constrained random mix
    for (int n = 0; n < 300; n++) begin
      logic [1:0] op;
      logic [5:0] id;
      op = 2'($urandom_range(0, 3));
      id = 6'($urandom_range(0, 63));
      if ($urandom_range(0, 3) != 0) id = 6'($urandom_range(0, numIds - 1));
      if (n % 40 == 7) dirWrite(3'($urandom_range(0, 1) * 4), $urandom());
      doReq(op, id, 1'b0);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule